// File: doc/BRIEF.md
# Serial CRC-4 Codeword Checker

This block decides whether a received 12-bit codeword is intact. The codeword is an 8-bit message followed by its 4-bit CRC remainder. A single start pulse captures the codeword. The block then feeds it one bit per clock, most significant bit first, into a 4-stage linear feedback divider for the generator x^4 + x^2 + 1. The divider starts from all zeros for every codeword.

After the last bit has been absorbed, the block shows a verdict for exactly one clock. A done strobe marks the result, and a pass flag in the same cycle tells whether the remainder left in the divider is zero. A zero remainder means the codeword is an exact multiple of the generator, so the word is accepted. The divider is then wiped, and the block waits for the next start.

Top module: `crc4_codeword_checker`

## Requirements
- R1: While reset (active low, asynchronous) is held, and right after it is released, `doneFlag` and `passFlag` are 0.
- R2: When `startPulse` is sampled high in the idle state, `doneFlag` goes high after exactly 12 further rising edges and stays high for exactly one cycle.
- R3: The codeword 12'b1101_1011_0110 (message 8'b11011011 followed by remainder 4'b0110) gives `passFlag` = 1 in the done cycle.
- R4: Any single-bit flip of the R3 codeword gives `passFlag` = 0 in the done cycle.
- R5: For any codeword, `passFlag` in the done cycle equals 1 exactly when the codeword, read with bit 11 as the x^11 coefficient, is divisible modulo 2 by x^4 + x^2 + 1.
- R6: A `startPulse` that arrives while a word is being shifted, or during the done cycle, has no effect. Neither the verdict nor the timing of the word in progress changes, and no extra done cycle follows.
- R7: The divider is cleared after every verdict, so a failing word has no influence on the verdict of the next word.
- R8: `passFlag` is 0 in every cycle in which `doneFlag` is 0.
- R9: Asserting reset in the middle of a word abandons that word. No done cycle follows for it, and the next started word is judged normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Starts a check; honoured only when idle |
| codeword | input | 12 | Message in bits 11..4, CRC remainder in bits 3..0; captured together with start |
| doneFlag | output | 1 | High for one cycle when a verdict is ready |
| passFlag | output | 1 | High in the done cycle when the remainder is zero |

## Verification
Two events can land in the same cycle: a new start request and a verdict or busy shift. The bench raises `startPulse` with a different codeword in the middle of the shift phase, and again in the very cycle in which `doneFlag` is high. It judges the outcome by the verdict of the original word, by the done timing, and by the absence of any extra done cycle afterwards. A failing word followed directly by a passing one shows that the verdict cycle also clears the divider in time for the next start.

// File: rtl/crc4_chk_pkg.sv
package crc4_chk_pkg;

  localparam int MSG_W  = 8;
  localparam int CRC_W  = 4;
  // generator taps below the leading term: x^4 + x^2 + 1 -> 4'b0101
  localparam logic [CRC_W-1:0] GEN_TAPS = 4'b0101;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } chkState_t;

  typedef struct packed {
    logic loadWord;
    logic shiftEn;
    logic clearRem;
  } chkStrobe_t;

endpackage

// File: rtl/crc4_chk_ctrl.sv
module crc4_chk_ctrl
  import crc4_chk_pkg::*;
#(
  parameter int WORD_W = 12,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  output chkStrobe_t        strobe,
  output chkState_t         stateNow,
  output logic [CNT_W-1:0]  bitCnt
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  chkState_t stateNext;
  logic      lastBit;

  assign lastBit = (stateNow == ST_SHIFT) && (bitCnt == LAST_CNT);

  always_comb begin
    stateNext = stateNow;
    unique case (stateNow)
      ST_IDLE:  if (startPulse) stateNext = ST_SHIFT;
      ST_SHIFT: if (lastBit)    stateNext = ST_DONE;
      ST_DONE:                  stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateNow <= ST_IDLE;
    else       stateNow <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    bitCnt <= '0;
    else if (lastBit)             bitCnt <= '0;
    else if (stateNow == ST_SHIFT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.loadWord = (stateNow == ST_IDLE) && startPulse;
    strobe.shiftEn  = (stateNow == ST_SHIFT);
    strobe.clearRem = (stateNow == ST_DONE);
  end

endmodule

// File: rtl/crc4_chk_datapath.sv
module crc4_chk_datapath
  import crc4_chk_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int REM_W  = 4,
  parameter logic [REM_W-1:0] TAPS = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  chkStrobe_t        strobe,
  input  logic [WORD_W-1:0] codeword,
  output logic [REM_W-1:0]  remReg
);

  logic [WORD_W-1:0] wordReg;
  logic [REM_W-1:0]  remNext;
  logic              inBit;
  logic              feedBack;

  assign inBit    = wordReg[WORD_W-1];
  assign feedBack = remReg[REM_W-1];

  // one division step per stage: shift up, fold the top stage into tapped positions
  for (genvar i = 0; i < REM_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign remNext[i] = inBit ^ (TAPS[i] & feedBack);
    end else begin : g_body
      assign remNext[i] = remReg[i-1] ^ (TAPS[i] & feedBack);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordReg <= '0;
    else if (strobe.loadWord) wordReg <= codeword;
    else if (strobe.shiftEn)  wordReg <= {wordReg[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remReg <= '0;
    else if (strobe.clearRem) remReg <= '0;
    else if (strobe.shiftEn)  remReg <= remNext;
  end

endmodule

// File: rtl/crc4_codeword_checker.sv
module crc4_codeword_checker
  import crc4_chk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic [11:0]  codeword,
  output logic         doneFlag,
  output logic         passFlag
);

  localparam int WORD_W = MSG_W + CRC_W;
  localparam int CNT_W  = $clog2(WORD_W);

  chkStrobe_t        strobe;
  chkState_t         stateNow;
  logic [CNT_W-1:0]  bitCnt;
  logic [CRC_W-1:0]  remReg;

  crc4_chk_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .strobe     (strobe),
    .stateNow   (stateNow),
    .bitCnt     (bitCnt)
  );

  crc4_chk_datapath #(.WORD_W(WORD_W), .REM_W(CRC_W), .TAPS(GEN_TAPS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .codeword (codeword),
    .remReg   (remReg)
  );

  assign doneFlag = (stateNow == ST_DONE);
  assign passFlag = doneFlag && (remReg == '0);

endmodule

// File: rtl/crc4_chk_sva.sv
module crc4_chk_sva
  import crc4_chk_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int CNT_W  = 4,
  parameter int REM_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             doneFlag,
  input logic             passFlag,
  input chkState_t        stateNow,
  input logic [CNT_W-1:0] bitCnt,
  input logic [REM_W-1:0] remReg
);

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);

  a_r2_start_enters_shift: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_IDLE && startPulse) |=> (stateNow == ST_SHIFT && bitCnt == '0));

  a_r2_last_bit_to_done: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_SHIFT && bitCnt == CNT_W'(WORD_W - 1)) |=> doneFlag);

  a_r6_shift_not_aborted: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_SHIFT) |=> (stateNow != ST_IDLE));

  a_r6_done_returns_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> (stateNow == ST_IDLE));

  a_r7_rem_cleared: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> (remReg == '0));

  a_r8_pass_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    passFlag |-> doneFlag);

  always_comb begin
    if (!rstN) a_r1_reset_quiet: assert (!doneFlag && !passFlag);
  end

endmodule

bind crc4_codeword_checker crc4_chk_sva #(
  .WORD_W(crc4_chk_pkg::MSG_W + crc4_chk_pkg::CRC_W),
  .CNT_W ($clog2(crc4_chk_pkg::MSG_W + crc4_chk_pkg::CRC_W)),
  .REM_W (crc4_chk_pkg::CRC_W)
) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .doneFlag   (doneFlag),
  .passFlag   (passFlag),
  .stateNow   (stateNow),
  .bitCnt     (bitCnt),
  .remReg     (remReg)
);

// File: tb/sim_crc4_codeword_checker.sv
`timescale 1ns/1ps
module sim_crc4_codeword_checker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [11:0] codeword = '0;
  logic        doneFlag;
  logic        passFlag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  crc4_codeword_checker u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .codeword(codeword), .doneFlag(doneFlag), .passFlag(passFlag)
  );

  // stimulus word and expected verdict: {codeword, pass}
  localparam logic [12:0] VEC [8] = '{
    {12'hDB6, 1'b1},  // R3 reference codeword
    {12'h015, 1'b1},  // the generator itself
    {12'h000, 1'b1},  // all zero
    {12'h041, 1'b1},  // x^6 + 1, multiple of G
    {12'hFFF, 1'b1},  // all ones, multiple of G
    {12'h001, 1'b0},
    {12'hDB7, 1'b0},
    {12'h800, 1'b0}
  };

  function automatic logic refPass(input logic [11:0] cw);
    logic [11:0] r = cw;
    for (int i = 11; i >= 4; i--)
      if (r[i]) r = r ^ (12'h015 << (i - 4));
    return (r[3:0] == 4'b0000);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      summary();
    end
  end

  // start a word; returns edges from load to done and verdict; -1 on timeout
  task automatic runWord(input logic [11:0] cw, input int midPokeAt,
                         output int edges, output logic verdict);
    @(negedge clk);
    codeword = cw; startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    edges = -1; verdict = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == midPokeAt) begin
        startPulse = 1'b1; codeword = ~cw;
      end else begin
        startPulse = 1'b0;
      end
      if (doneFlag) begin
        edges = n; verdict = passFlag;
        startPulse = 1'b0;
        break;
      end
    end
  endtask

  task automatic expectIdleAfterDone(input string req);
    @(negedge clk);
    check(!doneFlag, req, "done drops after one cycle", doneFlag, 0);
  endtask

  initial begin
    int e;
    logic v;
    int extra;

    // R1: reset state
    #2;
    check(!doneFlag && !passFlag, "R1", "flags during reset", {doneFlag, passFlag}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!doneFlag && !passFlag, "R1", "flags after reset", {doneFlag, passFlag}, 0);

    // R5 table walk, R2 timing
    foreach (VEC[k]) begin
      check(refPass(VEC[k][12:1]) == VEC[k][0], "R5", "table vs reference division",
            refPass(VEC[k][12:1]), VEC[k][0]);
      runWord(VEC[k][12:1], 0, e, v);
      check(e == 12, "R2", "edges from load to done", e, 12);
      check(v == VEC[k][0], "R5", "verdict", v, VEC[k][0]);
      expectIdleAfterDone("R2");
    end

    // R3 reference codeword
    runWord(12'hDB6, 0, e, v);
    check(v == 1'b1, "R3", "reference codeword passes", v, 1);
    expectIdleAfterDone("R8");
    check(!passFlag, "R8", "pass low outside done", passFlag, 0);

    // R4 single-bit flips
    for (int b = 0; b < 12; b++) begin
      runWord(12'hDB6 ^ (12'h001 << b), 0, e, v);
      check(v == 1'b0 && e == 12, "R4", $sformatf("flip bit %0d fails", b), v, 0);
    end

    // R6: start while shifting
    runWord(12'hDB6, 5, e, v);
    check(e == 12, "R6", "timing with mid-shift start", e, 12);
    check(v == 1'b1, "R6", "verdict with mid-shift start", v, 1);

    // R6: start in the done cycle
    runWord(12'h001, 0, e, v);
    startPulse = 1'b1; codeword = 12'hDB6;
    @(negedge clk);
    startPulse = 1'b0;
    extra = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (doneFlag) extra++;
    end
    check(extra == 0, "R6", "no done after start in done cycle", extra, 0);

    // R7: failing word then passing word back to back
    runWord(12'h7A3, 0, e, v);
    check(v == refPass(12'h7A3), "R7", "first word verdict", v, refPass(12'h7A3));
    runWord(12'hDB6, 0, e, v);
    check(v == 1'b1, "R7", "next word unaffected", v, 1);

    // R9: reset in mid-word
    @(negedge clk);
    codeword = 12'h001; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!doneFlag && !passFlag, "R9", "flags in mid-word reset", {doneFlag, passFlag}, 0);
    @(negedge clk);
    rstN = 1'b1;
    extra = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (doneFlag) extra++;
    end
    check(extra == 0, "R9", "abandoned word gives no done", extra, 0);
    runWord(12'hDB6, 0, e, v);
    check(e == 12 && v == 1'b1, "R9", "word after reset passes", v, 1);

    summary();
  end

endmodule